// File: doc/BRIEF.md
# SPI Interrupt Status Controller

This block gathers the interrupt causes of an SPI master that has byte-wide transmit and receive FIFOs and drives them onto one level-sensitive interrupt line. Three causes are events: transmit underflow, receive overflow and mode fault. Each one arrives as a single-cycle pulse and is latched until software clears it. The other four causes are recomputed every cycle from the FIFO state. Two of them compare occupancy counts against thresholds that software programs. The other two follow the FIFO full flags.

Software reaches the block through a simple register port. It has a write strobe with an address and data, and a combinational read path. Status bits are cleared by writing ones to them. The interrupt mask cannot be written directly. Software sets mask bits through a set register and clears them through a clear register, so no read-modify-write is needed. The interrupt output is the registered OR of the masked status bits.

Register addresses (3-bit): 0 status, 1 mask set, 2 mask clear, 3 mask, 4 transmit threshold, 5 receive threshold. Addresses 6 and 7 are unused.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Status bit positions are fixed as follows. Bit 0 is receive overflow, bit 1 is mode fault and bit 6 is transmit underflow. Bit 3 follows the transmit full flag and bit 5 follows the receive full flag. Bit 2 is set while transmit count < transmit threshold. Bit 4 is set while receive count >= receive threshold. Only bits 6:0 exist, and a status read returns them zero-extended.
- R2: Status bits 0, 1 and 6 are sticky. A pulse on the matching event input sets the bit at the next clock edge, and the bit stays set until software clears it.
- R3: A write to address 0 clears each sticky status bit whose data bit is 1 and leaves the others unchanged. The level bits 2, 3, 4 and 5 are not affected.
- R4: If an event pulse and a write-one-to-clear of the same bit fall in the same cycle, the event wins and the bit stays set.
- R5: A write to address 1 ORs data bits 6:0 into the mask. A write to address 2 clears the mask bits whose data bit is 1.
- R6: Address 3 reads the mask, and writes to it are ignored. Addresses 1, 2, 6 and 7 read as zero. Addresses 4 and 5 read back the thresholds from data bits CNT_W-1:0.
- R7: irq_o is set when (mask AND status) is non-zero, and it changes on the clock edge after the status or the mask changes.
- R8: After reset both thresholds are 1, the mask and the sticky bits are 0, and irq_o is 0.
- R9: At the threshold boundaries, bit 4 sets when the receive count equals the receive threshold and is clear one below it. Bit 2 clears when the transmit count equals the transmit threshold and is set one below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_count_i | input | CNT_W | Transmit FIFO occupancy |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| tx_full_i | input | 1 | Transmit FIFO full flag |
| rx_full_i | input | 1 | Receive FIFO full flag |
| tx_underflow_i | input | 1 | Transmit underflow event pulse |
| rx_overflow_i | input | 1 | Receive overflow event pulse |
| mode_fail_i | input | 1 | Mode fault event pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 3 | Write address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_raddr_i | input | 3 | Read address |
| reg_rdata_o | output | DATA_W | Read data, combinational |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The level bits in a status read follow the count and full inputs in the same cycle, with no clock edge in between. A sticky bit, a mask change or a threshold change becomes visible only after the edge that captures the event or the write. irq_o takes one more edge after that, because it samples the masked status that was present before the edge. For this reason the bench drives inputs on the falling edge. It computes in advance the interrupt value the next rising edge must produce, then compares irq_o and the read data at the following falling edge while the inputs are still held.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

   localparam int unsigned IRQ_BITS = 7;

   // status bit positions
   localparam int unsigned B_RX_OVF    = 0;
   localparam int unsigned B_MODE_FAIL = 1;
   localparam int unsigned B_TX_LOW    = 2;
   localparam int unsigned B_TX_FULL   = 3;
   localparam int unsigned B_RX_HIGH   = 4;
   localparam int unsigned B_RX_FULL   = 5;
   localparam int unsigned B_TX_UNDER  = 6;

   localparam int unsigned NUM_STICKY = 3;

   typedef logic [IRQ_BITS-1:0] irq_vec_t;

   typedef enum logic [2:0] {
      A_STAT  = 3'd0,
      A_MSET  = 3'd1,
      A_MCLR  = 3'd2,
      A_MASK  = 3'd3,
      A_TXTHR = 3'd4,
      A_RXTHR = 3'd5
   } reg_addr_e;

endpackage

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= 1'b0;
            else
               q <= (q & ~clr_i[i]) | set_i[i];   // event has priority
         end
         assign flag_o[i] = q;
      end
   endgenerate

endmodule

// File: rtl/spi_irq_level.sv
module spi_irq_level #(
   parameter int unsigned CNT_W     = 6,
   parameter bit          REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tx_count_i,
   input  logic [CNT_W-1:0] rx_count_i,
   input  logic [CNT_W-1:0] tx_thr_i,
   input  logic [CNT_W-1:0] rx_thr_i,
   input  logic             tx_full_i,
   input  logic             rx_full_i,
   output logic             tx_low_o,
   output logic             tx_full_o,
   output logic             rx_high_o,
   output logic             rx_full_o
);

   logic tx_low_c, rx_high_c;

   assign tx_low_c  = (tx_count_i <  tx_thr_i);
   assign rx_high_c = (rx_count_i >= rx_thr_i);

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tx_low_o  <= 1'b0;
               tx_full_o <= 1'b0;
               rx_high_o <= 1'b0;
               rx_full_o <= 1'b0;
            end else begin
               tx_low_o  <= tx_low_c;
               tx_full_o <= tx_full_i;
               rx_high_o <= rx_high_c;
               rx_full_o <= rx_full_i;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign tx_low_o   = tx_low_c;
         assign tx_full_o  = tx_full_i;
         assign rx_high_o  = rx_high_c;
         assign rx_full_o  = rx_full_i;
      end
   endgenerate

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
   import spi_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [2:0]        rd_addr_i,
   input  irq_vec_t          status_i,
   output irq_vec_t          mask_o,
   output logic [CNT_W-1:0]  tx_thr_o,
   output logic [CNT_W-1:0]  rx_thr_o,
   output irq_vec_t          stat_clr_o,
   output logic [DATA_W-1:0] rd_data_o
);

   localparam logic [CNT_W-1:0] THR_RST = CNT_W'(1);

   irq_vec_t         mask_q;
   logic [CNT_W-1:0] tx_thr_q, rx_thr_q;
   irq_vec_t         wbits;
   logic             unused_wdata;

   assign wbits        = wr_data_i[IRQ_BITS-1:0];
   assign unused_wdata = ^wr_data_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q   <= '0;
         tx_thr_q <= THR_RST;
         rx_thr_q <= THR_RST;
      end else if (wr_en_i) begin
         case (wr_addr_i)
            A_MSET:  mask_q   <= mask_q | wbits;
            A_MCLR:  mask_q   <= mask_q & ~wbits;
            A_TXTHR: tx_thr_q <= wr_data_i[CNT_W-1:0];
            A_RXTHR: rx_thr_q <= wr_data_i[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   assign stat_clr_o = (wr_en_i && wr_addr_i == A_STAT) ? wbits : '0;

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         A_STAT:  rd_data_o = DATA_W'(status_i);
         A_MASK:  rd_data_o = DATA_W'(mask_q);
         A_TXTHR: rd_data_o = DATA_W'(tx_thr_q);
         A_RXTHR: rd_data_o = DATA_W'(rx_thr_q);
         default: rd_data_o = '0;
      endcase
   end

   assign mask_o   = mask_q;
   assign tx_thr_o = tx_thr_q;
   assign rx_thr_o = rx_thr_q;

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
   import spi_irq_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 32,
   parameter int unsigned DATA_W     = 32,
   parameter bit          LEVEL_REG  = 1'b0,
   localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  tx_count_i,
   input  logic [CNT_W-1:0]  rx_count_i,
   input  logic              tx_full_i,
   input  logic              rx_full_i,
   input  logic              tx_underflow_i,
   input  logic              rx_overflow_i,
   input  logic              mode_fail_i,
   input  logic              reg_wr_i,
   input  logic [2:0]        reg_waddr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   input  logic [2:0]        reg_raddr_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o
);

   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("spi_irq_ctrl: FIFO_DEPTH must be at least 2");
      end
      if (DATA_W < IRQ_BITS || DATA_W < CNT_W) begin : g_bad_width
         $error("spi_irq_ctrl: DATA_W too narrow for status or threshold");
      end
   endgenerate

   irq_vec_t               status_w, mask_w, clr_w;
   logic [CNT_W-1:0]       tx_thr_w, rx_thr_w;
   logic [NUM_STICKY-1:0]  ev_set, ev_clr, ev_flag;
   logic                   tx_low, tx_full, rx_high, rx_full;
   logic                   irq_q;

   // sticky slot order: 0 rx overflow, 1 mode fault, 2 tx underflow
   assign ev_set = {tx_underflow_i, mode_fail_i, rx_overflow_i};
   assign ev_clr = {clr_w[B_TX_UNDER], clr_w[B_MODE_FAIL], clr_w[B_RX_OVF]};

   spi_irq_sticky #(.N(NUM_STICKY)) u_sticky (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (ev_set),
      .clr_i  (ev_clr),
      .flag_o (ev_flag)
   );

   spi_irq_level #(.CNT_W(CNT_W), .REGISTERED(LEVEL_REG)) u_level (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_count_i (tx_count_i),
      .rx_count_i (rx_count_i),
      .tx_thr_i   (tx_thr_w),
      .rx_thr_i   (rx_thr_w),
      .tx_full_i  (tx_full_i),
      .rx_full_i  (rx_full_i),
      .tx_low_o   (tx_low),
      .tx_full_o  (tx_full),
      .rx_high_o  (rx_high),
      .rx_full_o  (rx_full)
   );

   always_comb begin
      status_w              = '0;
      status_w[B_RX_OVF]    = ev_flag[0];
      status_w[B_MODE_FAIL] = ev_flag[1];
      status_w[B_TX_UNDER]  = ev_flag[2];
      status_w[B_TX_LOW]    = tx_low;
      status_w[B_TX_FULL]   = tx_full;
      status_w[B_RX_HIGH]   = rx_high;
      status_w[B_RX_FULL]   = rx_full;
   end

   spi_irq_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (reg_wr_i),
      .wr_addr_i  (reg_waddr_i),
      .wr_data_i  (reg_wdata_i),
      .rd_addr_i  (reg_raddr_i),
      .status_i   (status_w),
      .mask_o     (mask_w),
      .tx_thr_o   (tx_thr_w),
      .rx_thr_o   (rx_thr_w),
      .stat_clr_o (clr_w),
      .rd_data_o  (reg_rdata_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= |(mask_w & status_w);
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk
   import spi_irq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       irq_o,
   input logic       wr,
   input logic [2:0] waddr,
   input logic [6:0] wdata,
   input logic       rx_ovf,
   input logic [6:0] status,
   input logic [6:0] mask
);

   // R7: line follows the previous cycle's masked status
   a_r7_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == |($past(mask) & $past(status))));

   // R2: sticky bit holds without a clear
   a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (status[B_RX_OVF] && !(wr && waddr == A_STAT && wdata[B_RX_OVF]))
      |=> status[B_RX_OVF]);

   // R4: event beats a simultaneous clear
   a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovf |=> status[B_RX_OVF]);

   // R3: write-one clears when no event arrives
   a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && waddr == A_STAT && wdata[B_RX_OVF] && !rx_ovf) |=> !status[B_RX_OVF]);

   // R5: set register ORs bits in
   a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && waddr == A_MSET) |=> ((mask & $past(wdata)) == $past(wdata)));

   // R5: clear register removes bits
   a_r5_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && waddr == A_MCLR) |=> ((mask & $past(wdata)) == 7'd0));

   // R6: mask address is not writable
   a_r6_mask_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && waddr == A_MASK) |=> $stable(mask));

endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .irq_o  (irq_o),
   .wr     (reg_wr_i),
   .waddr  (reg_waddr_i),
   .wdata  (reg_wdata_i[6:0]),
   .rx_ovf (rx_overflow_i),
   .status (status_w),
   .mask   (mask_w)
);

// File: tb/spi_irq_ctrl_tb_top.sv
module spi_irq_ctrl_tb_top;

   localparam int DEPTH      = 32;
   localparam int CNT_W      = $clog2(DEPTH + 1);
   localparam int DW         = 32;
   localparam int CLK_PERIOD = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] tx_cnt = '0, rx_cnt = '0;
   logic             tx_full = 1'b0, rx_full = 1'b0;
   logic             ev_under = 1'b0, ev_ovf = 1'b0, ev_mode = 1'b0;
   logic             wr = 1'b0;
   logic [2:0]       waddr = '0, raddr = '0;
   logic [DW-1:0]    wdata = '0;
   logic [DW-1:0]    rdata;
   logic             irq;

   int n_chk = 0;
   int n_bad = 0;
   string cur_req = "R8";

   // bench model
   logic [6:0]       m_mask;
   logic [2:0]       m_sticky;   // 0 ovf, 1 mode, 2 under
   logic [CNT_W-1:0] m_txthr, m_rxthr;

   spi_irq_ctrl #(.FIFO_DEPTH(DEPTH), .DATA_W(DW)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .tx_count_i     (tx_cnt),
      .rx_count_i     (rx_cnt),
      .tx_full_i      (tx_full),
      .rx_full_i      (rx_full),
      .tx_underflow_i (ev_under),
      .rx_overflow_i  (ev_ovf),
      .mode_fail_i    (ev_mode),
      .reg_wr_i       (wr),
      .reg_waddr_i    (waddr),
      .reg_wdata_i    (wdata),
      .reg_raddr_i    (raddr),
      .reg_rdata_o    (rdata),
      .irq_o          (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [6:0] f_status();
      logic [6:0] s;
      s[0] = m_sticky[0];
      s[1] = m_sticky[1];
      s[2] = (tx_cnt < m_txthr);
      s[3] = tx_full;
      s[4] = (rx_cnt >= m_rxthr);
      s[5] = rx_full;
      s[6] = m_sticky[2];
      return s;
   endfunction

   function automatic logic [DW-1:0] f_read(logic [2:0] a);
      case (a)
         3'd0:    return DW'(f_status());
         3'd3:    return DW'(m_mask);
         3'd4:    return DW'(m_txthr);
         3'd5:    return DW'(m_rxthr);
         default: return '0;
      endcase
   endfunction

   task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   // one clock: predict, advance, compare, clear pulses
   task automatic cycle();
      logic [6:0] st, clr;
      logic       nirq;
      st   = f_status();
      nirq = |(m_mask & st);
      clr  = '0;
      if (wr) begin
         case (waddr)
            3'd0: clr = wdata[6:0];
            3'd1: m_mask = m_mask | wdata[6:0];
            3'd2: m_mask = m_mask & ~wdata[6:0];
            3'd4: m_txthr = wdata[CNT_W-1:0];
            3'd5: m_rxthr = wdata[CNT_W-1:0];
            default: ;
         endcase
      end
      m_sticky = (m_sticky & ~{clr[6], clr[1], clr[0]}) | {ev_under, ev_mode, ev_ovf};
      @(posedge clk);
      @(negedge clk);
      chk("irq_o", DW'(irq), DW'(nirq));
      chk($sformatf("read addr %0d", raddr), rdata, f_read(raddr));
      wr = 1'b0; ev_under = 1'b0; ev_ovf = 1'b0; ev_mode = 1'b0;
   endtask

   task automatic rd_check(logic [2:0] a);
      raddr = a;
      #1;
      chk($sformatf("read addr %0d", a), rdata, f_read(a));
   endtask

   task automatic wreg(logic [2:0] a, logic [DW-1:0] d);
      wr = 1'b1; waddr = a; wdata = d;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      m_mask = '0; m_sticky = '0;
      m_txthr = CNT_W'(1); m_rxthr = CNT_W'(1);

      // R8 reset values
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R8";
      chk("irq after reset", DW'(irq), '0);
      for (int a = 0; a < 8; a++) rd_check(3'(a));   // R6 readback covered too

      // R1 / R9 threshold boundaries
      cur_req = "R9";
      raddr = 3'd0;
      wreg(3'd5, 32'd5); cycle();
      wreg(3'd4, 32'd3); cycle();
      rx_cnt = 4; tx_cnt = 2; cycle();   // rx below, tx below
      rx_cnt = 5; tx_cnt = 3; cycle();   // rx equal, tx equal
      cur_req = "R1";
      tx_full = 1'b1; cycle();
      rx_full = 1'b1; tx_full = 1'b0; cycle();
      rx_full = 1'b0; tx_cnt = 0; rx_cnt = 0; cycle();

      // R2 sticky
      cur_req = "R2";
      ev_ovf = 1'b1; cycle();
      repeat (3) cycle();
      ev_mode = 1'b1; ev_under = 1'b1; cycle();
      cycle();

      // R3 write-one-to-clear
      cur_req = "R3";
      wreg(3'd0, 32'h01); cycle();
      tx_cnt = 0; rx_cnt = 10;
      wreg(3'd0, 32'h7F); cycle();   // level bits stay
      cycle();

      // R4 event wins
      cur_req = "R4";
      ev_ovf = 1'b1; cycle();
      ev_ovf = 1'b1; wreg(3'd0, 32'h01); cycle();
      cycle();

      // R5 / R7 mask and interrupt timing
      cur_req = "R7";
      wreg(3'd1, 32'h01); cycle();   // irq still low this edge
      cycle();                       // now high
      cur_req = "R5";
      wreg(3'd1, 32'h50); raddr = 3'd3; cycle();
      wreg(3'd2, 32'h41); cycle();
      cur_req = "R7";
      raddr = 3'd0; cycle();
      wreg(3'd0, 32'h7F); cycle();
      cycle();

      // R6 read-only mask and zero reads
      cur_req = "R6";
      raddr = 3'd3; wreg(3'd3, 32'h7F); cycle();
      for (int a = 0; a < 8; a++) rd_check(3'(a));

      // random phase
      cur_req = "R7";
      for (int i = 0; i < 800; i++) begin
         tx_cnt   = CNT_W'($urandom_range(0, DEPTH));
         rx_cnt   = CNT_W'($urandom_range(0, DEPTH));
         tx_full  = ($urandom_range(0, 7) == 0);
         rx_full  = ($urandom_range(0, 7) == 0);
         ev_ovf   = ($urandom_range(0, 5) == 0);
         ev_mode  = ($urandom_range(0, 5) == 0);
         ev_under = ($urandom_range(0, 5) == 0);
         raddr    = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 2) == 0) begin
            wreg(3'($urandom_range(0, 7)), $urandom());
            if (waddr == 3'd4 || waddr == 3'd5)
               wdata = DW'($urandom_range(0, DEPTH + 1));
         end
         cycle();
      end

      finish_run();
   end

endmodule